// File: doc/BRIEF.md
# Multicore Interrupt Distributor

This block gathers interrupt requests from three kinds of source and hands them to a small set of processor cores, four by default. Shared peripheral lines are steered to any subset of cores by a per-interrupt target mask. Each core owns a small bank of private peripheral lines that no other core can see. Software-generated interrupts are raised by a request that names a set of target cores and a number from 0 to 15, which lets cores signal each other. Each core owns its own bank of the sixteen software-generated interrupts.

Every interrupt carries its own four-state lifecycle (idle, pending, active, active-and-pending), an enable bit, a priority (smaller value is more urgent), and a group bit that sends it to the core's FIQ output instead of its IRQ output. The controller is non-vectored: a core pulses acknowledge and reads back the number of the interrupt it has claimed. When its handler is done, it writes that number to end-of-interrupt. Number ranges are fixed: 0..15 software-generated, 16.. private, 32.. shared. The all-ones number means "nothing to claim".

Top module: `mc_irq_distributor`

## Requirements
- R1: While reset is held and after it is released, every irq_o and fiq_o bit is low, and an acknowledge from any core returns 63 (all ones in the 6-bit number).
- R2: A pulse on shared line k of an enabled shared interrupt latches it pending. One clock after the pulse, exactly the cores set in its 4-bit target mask see their output raised, and an acknowledge returns number 32+k.
- R3: Private line k of core c (input bit c*2+k) is seen only by core c, under number 16+k. Other cores' outputs stay low and their acknowledges return 63.
- R4: A software request with target mask T and number n (0..15) makes interrupt n pending in the bank of every core set in T. Once enabled, each of those cores sees it and acknowledges number n.
- R5: An acknowledge returns its number on ack_id_o, with ack_vld_o high, one clock after ack_req_i. It moves the claimed interrupt out of pending. It claims the eligible interrupt with the smallest priority value, and the smaller number on a priority tie.
- R6: If a hardware line is still high when its interrupt is acknowledged, the interrupt becomes active-and-pending. It is not offered again until end-of-interrupt returns it to pending.
- R7: End-of-interrupt returns an active interrupt to idle. An end-of-interrupt naming an interrupt that is idle or pending changes nothing.
- R8: An acknowledge from a core with no eligible interrupt returns 63.
- R9: An interrupt whose group bit is 1 drives fiq_o instead of irq_o. For each core, any eligible group-1 interrupt outranks every group-0 one, so irq_o stays low while fiq_o is high.
- R10: A disabled interrupt still latches pending but is not offered. Enabling it later makes it visible without a new pulse.
- R11: Once one core has claimed a shared interrupt, the other targeted cores no longer see it, and their acknowledges return 63.
- R12: A software request to an active software-generated interrupt makes it active-and-pending. End-of-interrupt then leaves it pending and offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| shared_irq_i | input | NUM_SHARED | Shared peripheral request lines |
| priv_irq_i | input | NUM_CORES*PRIV_PER_CORE | Private lines, bit c*PRIV_PER_CORE+k is line k of core c |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_core_i | input | CW | Core bank for private and software-generated numbers |
| cfg_id_i | input | ID_W | Interrupt number being configured |
| cfg_en_i | input | 1 | Enable value |
| cfg_fiq_i | input | 1 | Group value, 1 routes to FIQ |
| cfg_prio_i | input | PRIO_W | Priority value, smaller is more urgent |
| cfg_tgt_i | input | NUM_CORES | Target mask, used by shared numbers only |
| ack_req_i | input | 1 | Acknowledge strobe |
| ack_core_i | input | CW | Core that acknowledges |
| ack_vld_o | output | 1 | Acknowledge result valid |
| ack_id_o | output | ID_W | Claimed number, or all ones |
| eoi_req_i | input | 1 | End-of-interrupt strobe |
| eoi_core_i | input | CW | Core that signals completion |
| eoi_id_i | input | ID_W | Completed interrupt number |
| sgi_req_i | input | 1 | Software-generated interrupt request strobe |
| sgi_tgt_i | input | NUM_CORES | Target cores of the request |
| sgi_id_i | input | 4 | Software-generated interrupt number |
| irq_o | output | NUM_CORES | Per-core normal interrupt output |
| fiq_o | output | NUM_CORES | Per-core fast interrupt output |

## Verification
The assertions check the per-interrupt lifecycle every cycle. An acknowledge only ever lands on a pending interrupt. Acknowledge with the line high gives active-and-pending, and end-of-interrupt leaves active-and-pending or active in the proper state. At the ports, irq_o and fiq_o are never both high for a core, every acknowledge answers after one cycle, and the all-ones answer comes exactly when the acknowledging core had nothing on its outputs. Only the bench scenarios show which interrupt wins on priority, on number ties and on group, and that private lines stay private. They also show that a shared claim hides the interrupt from the other targets, that software requests land in the right banks, and that disabled interrupts keep their pending state.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int SGI_COUNT   = 16;
  localparam int PRIV_BASE   = 16;
  localparam int SHARED_BASE = 32;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PEND    = 2'd1,
    ST_ACT     = 2'd2,
    ST_ACTPEND = 2'd3
  } irq_state_e;
endpackage

// File: rtl/irqd_rst_sync.sv
module irqd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irqd_cell.sv
module irqd_cell
  import irqd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  input  logic       swset_i,
  input  logic       ack_i,
  input  logic       eoi_i,
  output irq_state_e st_o
);
  irq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (line_i || swset_i) st_d = ST_PEND;
      ST_PEND:    if (ack_i) st_d = line_i ? ST_ACTPEND : ST_ACT;
      ST_ACT: begin
        if (eoi_i)        st_d = swset_i ? ST_PEND : ST_IDLE;
        else if (swset_i) st_d = ST_ACTPEND;
      end
      ST_ACTPEND: if (eoi_i) st_d = ST_PEND;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

  // R5: only a pending interrupt can be claimed
  p_ack_on_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |-> st_q == ST_PEND);
  // R6: claim while the line is high leaves a pending copy behind
  p_ack_line_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && line_i) |=> st_q == ST_ACTPEND);
  // R6: completion of active-and-pending returns to pending
  p_eoi_actpend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACTPEND && eoi_i) |=> st_q == ST_PEND);
  // R7: completion of a plain active interrupt returns to idle
  p_eoi_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACT && eoi_i && !swset_i) |=> st_q == ST_IDLE);
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter #(
  parameter int NSLOT = 80,
  parameter int PW    = 3,
  parameter int ID_W  = 6,
  parameter int SW    = 7
) (
  input  logic [NSLOT-1:0]           elig_i,
  input  logic [NSLOT-1:0]           fiq_i,
  input  logic [NSLOT-1:0][PW-1:0]   prio_i,
  input  logic [NSLOT-1:0][ID_W-1:0] id_i,
  output logic                       vld_o,
  output logic [SW-1:0]              slot_o,
  output logic [ID_W-1:0]            id_o,
  output logic                       fiq_o
);
  localparam int KW = 1 + PW + ID_W;

  logic [KW-1:0] best_key;
  logic [KW-1:0] cand_key;

  // ordering key: group-1 first, then priority value, then number
  always_comb begin
    vld_o    = 1'b0;
    slot_o   = '0;
    best_key = '1;
    cand_key = '1;
    for (int s = 0; s < NSLOT; s++) begin
      cand_key = {~fiq_i[s], prio_i[s], id_i[s]};
      if (elig_i[s] && (!vld_o || cand_key < best_key)) begin
        vld_o    = 1'b1;
        slot_o   = SW'(s);
        best_key = cand_key;
      end
    end
    id_o  = best_key[ID_W-1:0];
    fiq_o = vld_o & ~best_key[KW-1];
  end
endmodule

// File: rtl/mc_irq_distributor.sv
module mc_irq_distributor
  import irqd_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int NUM_SHARED    = 8,
  parameter int PRIV_PER_CORE = 2,
  parameter int PRIO_W        = 3,
  parameter int ID_W          = 6,
  parameter int CW            = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_SHARED-1:0]              shared_irq_i,
  input  logic [NUM_CORES*PRIV_PER_CORE-1:0] priv_irq_i,
  input  logic                               cfg_we_i,
  input  logic [CW-1:0]                      cfg_core_i,
  input  logic [ID_W-1:0]                    cfg_id_i,
  input  logic                               cfg_en_i,
  input  logic                               cfg_fiq_i,
  input  logic [PRIO_W-1:0]                  cfg_prio_i,
  input  logic [NUM_CORES-1:0]               cfg_tgt_i,
  input  logic                               ack_req_i,
  input  logic [CW-1:0]                      ack_core_i,
  output logic                               ack_vld_o,
  output logic [ID_W-1:0]                    ack_id_o,
  input  logic                               eoi_req_i,
  input  logic [CW-1:0]                      eoi_core_i,
  input  logic [ID_W-1:0]                    eoi_id_i,
  input  logic                               sgi_req_i,
  input  logic [NUM_CORES-1:0]               sgi_tgt_i,
  input  logic [3:0]                         sgi_id_i,
  output logic [NUM_CORES-1:0]               irq_o,
  output logic [NUM_CORES-1:0]               fiq_o
);
  localparam int NC       = NUM_CORES;
  localparam int N_SGI    = NC * SGI_COUNT;
  localparam int N_PRIV   = NC * PRIV_PER_CORE;
  localparam int NSLOT    = N_SGI + N_PRIV + NUM_SHARED;
  localparam int SW       = $clog2(NSLOT);
  localparam logic [ID_W-1:0] SPURIOUS = '1;

  logic rst_q_n;

  irqd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  // number space: 0..15 banked per core, 16.. banked per core, 32.. shared
  function automatic logic [SW:0] map_slot(input logic [CW-1:0] core,
                                           input logic [ID_W-1:0] id);
    int c;
    int i;
    c = int'(core);
    i = int'(id);
    if (i < SGI_COUNT && c < NC)
      return {1'b1, SW'(c * SGI_COUNT + i)};
    if (i >= PRIV_BASE && i < PRIV_BASE + PRIV_PER_CORE && c < NC)
      return {1'b1, SW'(N_SGI + c * PRIV_PER_CORE + i - PRIV_BASE)};
    if (i >= SHARED_BASE && i < SHARED_BASE + NUM_SHARED)
      return {1'b1, SW'(N_SGI + N_PRIV + i - SHARED_BASE)};
    return '0;
  endfunction

  logic          cfg_hit, eoi_hit;
  logic [SW-1:0] cfg_slot, eoi_slot;

  assign {cfg_hit, cfg_slot} = map_slot(cfg_core_i, cfg_id_i);
  assign {eoi_hit, eoi_slot} = map_slot(eoi_core_i, eoi_id_i);

  // per-core arbitration results
  logic [NC-1:0]           best_vld;
  logic [NC-1:0]           best_fiq;
  logic [SW-1:0]           best_slot [NC];
  logic [ID_W-1:0]         best_id   [NC];
  logic                    ack_hit;
  logic [SW-1:0]           ack_slot;

  assign ack_hit  = ack_req_i && best_vld[ack_core_i];
  assign ack_slot = best_slot[ack_core_i];

  // per-slot signals
  irq_state_e              st_w    [NSLOT];
  logic [NC-1:0]           owner_w [NSLOT];
  logic                    en_q    [NSLOT];
  logic                    fiq_q   [NSLOT];
  logic [PRIO_W-1:0]       prio_q  [NSLOT];
  logic [ID_W-1:0]         id_w    [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic cfg_wr;
    logic line;
    logic swset;

    assign cfg_wr = cfg_we_i && cfg_hit && (cfg_slot == SW'(s));

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        en_q[s]   <= 1'b0;
        fiq_q[s]  <= 1'b0;
        prio_q[s] <= '0;
      end else if (cfg_wr) begin
        en_q[s]   <= cfg_en_i;
        fiq_q[s]  <= cfg_fiq_i;
        prio_q[s] <= cfg_prio_i;
      end
    end

    if (s < N_SGI) begin : g_sgi
      localparam int OWN = s / SGI_COUNT;
      localparam int NUM = s % SGI_COUNT;
      assign line       = 1'b0;
      assign swset      = sgi_req_i && sgi_tgt_i[OWN] && (sgi_id_i == 4'(NUM));
      assign owner_w[s] = NC'(1) << OWN;
      assign id_w[s]    = ID_W'(NUM);
    end else if (s < N_SGI + N_PRIV) begin : g_priv
      localparam int OWN = (s - N_SGI) / PRIV_PER_CORE;
      localparam int NUM = (s - N_SGI) % PRIV_PER_CORE;
      assign line       = priv_irq_i[s - N_SGI];
      assign swset      = 1'b0;
      assign owner_w[s] = NC'(1) << OWN;
      assign id_w[s]    = ID_W'(PRIV_BASE + NUM);
    end else begin : g_shared
      localparam int NUM = s - N_SGI - N_PRIV;
      logic [NC-1:0] tgt_q;
      always_ff @(posedge clk or negedge rst_q_n) begin
        if (!rst_q_n)    tgt_q <= '0;
        else if (cfg_wr) tgt_q <= cfg_tgt_i;
      end
      assign line       = shared_irq_i[NUM];
      assign swset      = 1'b0;
      assign owner_w[s] = tgt_q;
      assign id_w[s]    = ID_W'(SHARED_BASE + NUM);
    end

    irqd_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .line_i  (line),
      .swset_i (swset),
      .ack_i   (ack_hit && (ack_slot == SW'(s))),
      .eoi_i   (eoi_req_i && eoi_hit && (eoi_slot == SW'(s))),
      .st_o    (st_w[s])
    );
  end

  // pack per-slot views for the arbiters
  logic [NC-1:0][NSLOT-1:0]       elig;
  logic [NSLOT-1:0]               fiq_vec;
  logic [NSLOT-1:0][PRIO_W-1:0]   prio_vec;
  logic [NSLOT-1:0][ID_W-1:0]     id_vec;

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      fiq_vec[s]  = fiq_q[s];
      prio_vec[s] = prio_q[s];
      id_vec[s]   = id_w[s];
      for (int c = 0; c < NC; c++)
        elig[c][s] = (st_w[s] == ST_PEND) && en_q[s] && owner_w[s][c];
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_core
    irqd_arbiter #(.NSLOT(NSLOT), .PW(PRIO_W), .ID_W(ID_W), .SW(SW)) u_arb (
      .elig_i (elig[c]),
      .fiq_i  (fiq_vec),
      .prio_i (prio_vec),
      .id_i   (id_vec),
      .vld_o  (best_vld[c]),
      .slot_o (best_slot[c]),
      .id_o   (best_id[c]),
      .fiq_o  (best_fiq[c])
    );
    assign fiq_o[c] = best_vld[c] &  best_fiq[c];
    assign irq_o[c] = best_vld[c] & ~best_fiq[c];
  end

  // acknowledge answer register
  logic            ack_vld_d;
  logic [ID_W-1:0] ack_id_d;

  always_comb begin
    ack_vld_d = ack_req_i;
    ack_id_d  = ack_hit ? best_id[ack_core_i] : SPURIOUS;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ack_vld_o <= 1'b0;
      ack_id_o  <= SPURIOUS;
    end else begin
      ack_vld_o <= ack_vld_d;
      if (ack_req_i) ack_id_o <= ack_id_d;
    end
  end

  // R9: a core never has both outputs raised
  p_fiq_excl_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (irq_o & fiq_o) == '0);
  // R5: every acknowledge is answered one cycle later
  p_ack_latency_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    ack_req_i |=> ack_vld_o);
  // R8: all-ones answer exactly when the core had nothing to claim
  p_spurious_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    ack_vld_o |-> ((ack_id_o == SPURIOUS) ==
                   !$past(|((irq_o | fiq_o) & (NC'(1) << ack_core_i)))));
endmodule

// File: tb/tb_mc_irq_distributor.sv
module tb_mc_irq_distributor;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] shared_irq;
  logic [7:0] priv_irq;
  logic       cfg_we;
  logic [1:0] cfg_core;
  logic [5:0] cfg_id;
  logic       cfg_en, cfg_fiq;
  logic [2:0] cfg_prio;
  logic [3:0] cfg_tgt;
  logic       ack_req;
  logic [1:0] ack_core;
  logic       ack_vld;
  logic [5:0] ack_id;
  logic       eoi_req;
  logic [1:0] eoi_core;
  logic [5:0] eoi_id;
  logic       sgi_req;
  logic [3:0] sgi_tgt;
  logic [3:0] sgi_id;
  logic [3:0] irq, fiq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  mc_irq_distributor dut (
    .clk(clk), .rst_n(rst_n), .shared_irq_i(shared_irq), .priv_irq_i(priv_irq),
    .cfg_we_i(cfg_we), .cfg_core_i(cfg_core), .cfg_id_i(cfg_id), .cfg_en_i(cfg_en),
    .cfg_fiq_i(cfg_fiq), .cfg_prio_i(cfg_prio), .cfg_tgt_i(cfg_tgt),
    .ack_req_i(ack_req), .ack_core_i(ack_core), .ack_vld_o(ack_vld), .ack_id_o(ack_id),
    .eoi_req_i(eoi_req), .eoi_core_i(eoi_core), .eoi_id_i(eoi_id),
    .sgi_req_i(sgi_req), .sgi_tgt_i(sgi_tgt), .sgi_id_i(sgi_id),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] core, input logic [5:0] id, input logic en,
                     input logic fq, input logic [2:0] pr, input logic [3:0] tg);
    cfg_we = 1; cfg_core = core; cfg_id = id; cfg_en = en;
    cfg_fiq = fq; cfg_prio = pr; cfg_tgt = tg;
    step();
    cfg_we = 0;
  endtask

  task automatic do_ack(input logic [1:0] core, input logic [5:0] exp, input string tag);
    ack_req = 1; ack_core = core;
    step();
    ack_req = 0;
    check({tag, " ack valid (R5)"}, 32'(ack_vld), 32'd1);
    check({tag, " ack number"}, 32'(ack_id), 32'(exp));
  endtask

  task automatic do_eoi(input logic [1:0] core, input logic [5:0] id);
    eoi_req = 1; eoi_core = core; eoi_id = id;
    step();
    eoi_req = 0;
  endtask

  task automatic do_sgi(input logic [3:0] tg, input logic [3:0] id);
    sgi_req = 1; sgi_tgt = tg; sgi_id = id;
    step();
    sgi_req = 0;
  endtask

  task automatic pulse(input logic [7:0] lines);
    shared_irq = lines;
    step();
    shared_irq = '0;
  endtask

  // {en, fiq, target[3:0], exp_irq[3:0], exp_fiq[3:0]} for shared line 0 (number 32)
  localparam logic [13:0] VEC [7] = '{
    {1'b1, 1'b0, 4'b0001, 4'b0001, 4'b0000},
    {1'b1, 1'b0, 4'b1010, 4'b1010, 4'b0000},
    {1'b1, 1'b1, 4'b1111, 4'b0000, 4'b1111},
    {1'b0, 1'b0, 4'b1111, 4'b0000, 4'b0000},
    {1'b1, 1'b1, 4'b0110, 4'b0000, 4'b0110},
    {1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0000},
    {1'b1, 1'b0, 4'b1000, 4'b1000, 4'b0000}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; shared_irq = '0; priv_irq = '0; cfg_we = 0; cfg_core = '0; cfg_id = '0;
    cfg_en = 0; cfg_fiq = 0; cfg_prio = '0; cfg_tgt = '0; ack_req = 0; ack_core = '0;
    eoi_req = 0; eoi_core = '0; eoi_id = '0; sgi_req = 0; sgi_tgt = '0; sgi_id = '0;
    repeat (4) step();
    check("R1 irq in reset", 32'(irq), 32'd0);
    check("R1 fiq in reset", 32'(fiq), 32'd0);
    rst_n = 1;
    repeat (3) step();
    check("R1 irq after reset", 32'(irq), 32'd0);
    check("R1 fiq after reset", 32'(fiq), 32'd0);
    do_ack(2'd0, 6'd63, "R1 R8 idle core0");
    do_ack(2'd3, 6'd63, "R1 R8 idle core3");

    // table walk on shared line 0: R2, R9, R10
    for (int i = 0; i < 7; i++) begin
      automatic logic [13:0] v = VEC[i];
      automatic int first = -1;
      cfg(2'd0, 6'd32, v[13], v[12], 3'd4, v[11:8]);
      pulse(8'h01);
      check($sformatf("R2 R9 R10 vec%0d irq", i), 32'(irq), 32'(v[7:4]));
      check($sformatf("R2 R9 R10 vec%0d fiq", i), 32'(fiq), 32'(v[3:0]));
      for (int c = 3; c >= 0; c--) if (v[8+c]) first = c;
      if (v[13] && first >= 0) begin
        do_ack(2'(first), 6'd32, $sformatf("R2 vec%0d", i));
        do_eoi(2'(first), 6'd32);
        check($sformatf("R7 vec%0d cleared", i), 32'(irq | fiq), 32'd0);
      end
    end

    // private lines: R3, R6, R7
    cfg(2'd2, 6'd16, 1'b1, 1'b0, 3'd1, 4'b0000);
    priv_irq[4] = 1'b1;
    step();
    check("R3 only owner core sees private", 32'(irq), 32'b0100);
    do_ack(2'd0, 6'd63, "R3 other core");
    do_ack(2'd2, 6'd16, "R3 owner");
    check("R6 line high gives active-and-pending", 32'(irq), 32'd0);
    do_eoi(2'd2, 6'd16);
    check("R6 eoi returns to pending", 32'(irq), 32'b0100);
    priv_irq[4] = 1'b0;
    do_ack(2'd2, 6'd16, "R6 reclaim");
    do_eoi(2'd2, 6'd16);
    check("R7 eoi of active gives idle", 32'(irq), 32'd0);
    do_ack(2'd2, 6'd63, "R7 idle after eoi");

    // software-generated: R4, R12
    cfg(2'd1, 6'd5, 1'b1, 1'b0, 3'd2, 4'b0000);
    cfg(2'd3, 6'd5, 1'b1, 1'b0, 3'd2, 4'b0000);
    do_sgi(4'b1010, 4'd5);
    check("R4 sgi reaches targets", 32'(irq), 32'b1010);
    do_ack(2'd3, 6'd5, "R4 core3");
    do_ack(2'd1, 6'd5, "R4 core1");
    check("R4 both claimed", 32'(irq), 32'd0);
    do_sgi(4'b0010, 4'd5);
    check("R12 active-and-pending not offered", 32'(irq), 32'd0);
    do_eoi(2'd1, 6'd5);
    check("R12 pending after eoi", 32'(irq), 32'b0010);
    do_ack(2'd1, 6'd5, "R12 reclaim");
    do_eoi(2'd1, 6'd5);
    do_eoi(2'd3, 6'd5);
    check("R4 all done", 32'(irq), 32'd0);

    // priority and tie order: R5
    cfg(2'd0, 6'd33, 1'b1, 1'b0, 3'd3, 4'b0001);
    cfg(2'd0, 6'd34, 1'b1, 1'b0, 3'd1, 4'b0001);
    pulse(8'b0000_0110);
    do_ack(2'd0, 6'd34, "R5 smaller value wins");
    do_ack(2'd0, 6'd33, "R5 next");
    check("R5 nothing left pending", 32'(irq), 32'd0);
    do_eoi(2'd0, 6'd34);
    do_eoi(2'd0, 6'd33);
    cfg(2'd0, 6'd35, 1'b1, 1'b0, 3'd2, 4'b0001);
    cfg(2'd0, 6'd36, 1'b1, 1'b0, 3'd2, 4'b0001);
    pulse(8'b0001_1000);
    do_ack(2'd0, 6'd35, "R5 tie smaller number");
    do_ack(2'd0, 6'd36, "R5 tie second");
    do_eoi(2'd0, 6'd35);
    do_eoi(2'd0, 6'd36);

    // ignored completions: R7
    do_eoi(2'd0, 6'd33);
    do_ack(2'd0, 6'd63, "R7 eoi on idle ignored");
    pulse(8'b0000_0010);
    do_eoi(2'd0, 6'd33);
    check("R7 eoi on pending ignored", 32'(irq), 32'b0001);
    do_ack(2'd0, 6'd33, "R7 still pending");
    do_eoi(2'd0, 6'd33);

    // group precedence: R9
    cfg(2'd0, 6'd37, 1'b1, 1'b1, 3'd7, 4'b0010);
    cfg(2'd0, 6'd38, 1'b1, 1'b0, 3'd0, 4'b0010);
    pulse(8'b0110_0000);
    check("R9 fiq raised", 32'(fiq), 32'b0010);
    check("R9 irq held low", 32'(irq), 32'd0);
    do_ack(2'd1, 6'd37, "R9 fiq claimed first");
    check("R9 irq after fiq claimed", 32'(irq), 32'b0010);
    do_ack(2'd1, 6'd38, "R9 irq claimed");
    do_eoi(2'd1, 6'd37);
    do_eoi(2'd1, 6'd38);

    // shared claim hides from other targets: R11
    cfg(2'd0, 6'd39, 1'b1, 1'b0, 3'd0, 4'b0011);
    pulse(8'b1000_0000);
    check("R11 both targets see", 32'(irq), 32'b0011);
    do_ack(2'd0, 6'd39, "R11 core0 claims");
    check("R11 hidden from core1", 32'(irq), 32'd0);
    do_ack(2'd1, 6'd63, "R11 core1 nothing");
    do_eoi(2'd0, 6'd39);
    check("R11 idle", 32'(irq | fiq), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule